// File: doc/BRIEF.md
# Command-Driven SPI Master Engine

This block is a serial-peripheral master that runs one frame for each entry in a small transmit queue. Each entry pairs a data word with a command. The command picks one of two stored attribute sets and the chip-select lines to drive for that frame. Each attribute set holds the frame length, the clock polarity, the clock phase, the bit order and the clock divider. Because of this, the clock shape, the length and the selected slave can all change from one frame to the next. The block generates SCK and active-low chip selects. It shifts the data word out on SOUT, samples SIN, and writes each received word into a receive queue that the host drains through a pop port.

The host first writes the attribute sets through a simple write port. It then pushes entries while the enable input is high. If enable is low, entries stay queued and nothing is driven on the bus. A keep-select bit in the command lets two consecutive frames to the same slave share one select assertion. If the receive queue is full when a frame ends, the engine stalls with the select still asserted. It reports the stall until the host makes room.

Top module: `spim_cmd_master`

## Requirements
- R1: After reset, cs_n is all ones, sck and sout are 0, rx_stall is 0, both queues report empty, and neither queue reports full.
- R2: A frame starts only when en is 1 and the transmit queue holds an entry. With en at 0, pushed entries stay queued, tx_empty stays 0 and cs_n stays all ones.
- R3: The command's set index (push_set) picks the attribute set for the frame. A frame has cfg_size_m1+1 bits (1 to 32), taken from bits [size_m1:0] of the data word.
- R4: While a frame runs, sck rests at the set's CPOL level and toggles 2×(size_m1+1) times. It ends the frame at that level.
- R5: With CPHA 0, sin is sampled on the leading (first) edge of each clock period and sout changes on the trailing edge. With CPHA 1, sout changes on the leading edge and sin is sampled on the trailing edge.
- R6: With cfg_lsb_first at 0, bits go out from bit size_m1 down to bit 0; with 1, from bit 0 upward. The received word is right-aligned, placed in the same bit order, with zeros above bit size_m1.
- R7: During a frame, cs_n equals the inverse of the command's select mask. Between frames it is all ones. An asserted select pattern only ever changes to all ones.
- R8: One half-period lasts cfg_div+1 clock cycles. At least one half-period separates select assertion from the first sck edge, and the last sck edge from select release. The sck output is stable in the cycle after a select asserts.
- R9: If a frame's keep-select bit is 1, en is 1, and the next queued entry has the same mask, the select stays asserted into that next frame. Otherwise it is released for at least one cycle.
- R10: Received words come out of the 4-entry receive queue in frame order on rx_pop. rx_full and rx_empty are never both 1.
- R11: If the receive queue is full when a frame ends, rx_stall goes to 1 and the word is held. The select stays asserted, sck does not toggle, and no other frame starts. The word is written once a pop frees a slot, and then rx_stall returns to 0.
- R12: The transmit queue holds 4 entries. A push while tx_full is 1 is dropped, and that entry never produces a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows frames to start |
| cfg_write | input | 1 | Writes one attribute set |
| cfg_set | input | SELW | Attribute set to write |
| cfg_size_m1 | input | 5 | Frame length minus one |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase (0: sample on leading edge) |
| cfg_lsb_first | input | 1 | Bit order (1: LSB first) |
| cfg_div | input | DIV_W | Half-period length minus one, in clocks |
| push_valid | input | 1 | Pushes one transmit entry |
| push_data | input | 32 | Data word |
| push_set | input | SELW | Attribute set index of the command |
| push_cs_mask | input | NCS | Selects to assert (bit set = assert) |
| push_keep_cs | input | 1 | Keep select into the next matching frame |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Removes the head received word |
| rx_data | output | 32 | Head received word |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_stall | output | 1 | Frame ended with the receive queue full |
| sck | output | 1 | Serial clock |
| cs_n | output | NCS | Active-low chip selects |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |

## Verification
A behavioural slave in the bench follows every clock. It recovers the bits sent from the sck edges, using the expected frame's polarity and phase, and answers on sin with a known reply word. The test frames use all four clock modes, both bit orders, the 1-bit, 8-bit, 16-bit and 32-bit lengths, and dividers 0 to 3. A wrong sampling edge, a wrong bit order, a wrong length or a wrong divider each produces a different mismatch between the sent and received words. Keep-select is tried with equal masks and with different masks, so select release is checked both ways. A burst of five pushes against four slots and five frames with no pops check that the dropped push never produces a frame and that the stalled word is delivered after the pop.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned SPIM_DW    = 32;
  localparam int unsigned SPIM_DIV_W = 8;

  typedef struct packed {
    logic [4:0]            size_m1;
    logic                  cpol;
    logic                  cpha;
    logic                  lsbf;
    logic [SPIM_DIV_W-1:0] div;
  } spim_attr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_DONE
  } spim_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wr, rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr    = push && !full;
  assign rd    = pop && !empty;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spim_attr_bank.sv
module spim_attr_bank
  import spim_pkg::*;
#(
  parameter int NSET = 2,
  parameter int SELW = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  spim_attr_t      wattr,
  input  logic [SELW-1:0] rsel,
  output spim_attr_t      rattr
);
  localparam spim_attr_t RESET_ATTR = '{size_m1: 5'd7, cpol: 1'b0, cpha: 1'b0,
                                        lsbf: 1'b0, div: SPIM_DIV_W'(1)};
  spim_attr_t bank [NSET];

  for (genvar g = 0; g < NSET; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst)                            bank[g] <= RESET_ATTR;
      else if (we && wsel == SELW'(g))    bank[g] <= wattr;
    end
  end

  assign rattr = bank[rsel];
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tx_empty,
  input  logic [SPIM_DW-1:0] head_data,
  input  logic [NCS-1:0]     head_mask,
  input  logic               head_cont,
  input  spim_attr_t         head_attr,
  input  logic               rx_full,
  input  logic               sin,
  output logic               tx_pop,
  output logic               rx_push,
  output logic [SPIM_DW-1:0] rx_word,
  output logic               sck,
  output logic               sout,
  output logic               rx_stall,
  output logic [NCS-1:0]     cs_n
);
  localparam int IW = $clog2(SPIM_DW);

  spim_state_t           state;
  spim_attr_t            cur;
  logic [NCS-1:0]        cur_mask;
  logic                  cur_cont;
  logic [SPIM_DW-1:0]    txw;
  logic [IW-1:0]         idx, nidx, first_idx;
  logic [IW:0]           edges;
  logic [SPIM_DIV_W-1:0] tmr;
  logic                  lead_edge, last_edge, start_new, chain;

  always_comb begin
    nidx      = cur.lsbf ? idx + 1'b1 : idx - 1'b1;
    first_idx = head_attr.lsbf ? '0 : IW'(head_attr.size_m1);
    lead_edge = ~edges[0];
    last_edge = (edges == {cur.size_m1, 1'b1});
    start_new = (state == S_IDLE) && en && !tx_empty;
    chain     = (state == S_DONE) && !rx_full && cur_cont && en && !tx_empty &&
                (head_mask == cur_mask);
    tx_pop    = start_new || chain;
    rx_push   = (state == S_DONE) && !rx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur      <= '0;
      cur_mask <= '0;
      cur_cont <= 1'b0;
      txw      <= '0;
      rx_word  <= '0;
      idx      <= '0;
      edges    <= '0;
      tmr      <= '0;
      sck      <= 1'b0;
      sout     <= 1'b0;
      rx_stall <= 1'b0;
      cs_n     <= '1;
    end else begin
      rx_stall <= (state == S_DONE) && rx_full;
      if (tx_pop) begin
        cur      <= head_attr;
        cur_mask <= head_mask;
        cur_cont <= head_cont;
        txw      <= head_data;
        rx_word  <= '0;
        idx      <= first_idx;
        sout     <= head_data[first_idx];
        sck      <= head_attr.cpol;
        cs_n     <= ~head_mask;
        edges    <= '0;
        tmr      <= head_attr.div;
        state    <= S_LEAD;
      end else begin
        case (state)
          S_LEAD: begin
            if (tmr == '0) state <= S_SHIFT;
            else           tmr   <= tmr - 1'b1;
          end
          S_SHIFT: begin
            if (tmr != '0) begin
              tmr <= tmr - 1'b1;
            end else begin
              sck   <= ~sck;
              tmr   <= cur.div;
              edges <= edges + 1'b1;
              if (lead_edge) begin
                if (cur.cpha) sout         <= txw[idx];
                else          rx_word[idx] <= sin;
              end else begin
                if (cur.cpha)  rx_word[idx] <= sin;
                else           sout         <= txw[nidx];
                idx <= nidx;
                if (last_edge) state <= S_TRAIL;
              end
            end
          end
          S_TRAIL: begin
            if (tmr == '0) state <= S_DONE;
            else           tmr   <= tmr - 1'b1;
          end
          S_DONE: begin
            if (!rx_full) begin
              cs_n  <= '1;
              state <= S_IDLE;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/spim_cmd_master.sv
module spim_cmd_master
  import spim_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int NSET  = 2,
  parameter int DEPTH = 4,
  parameter int SELW  = (NSET > 1) ? $clog2(NSET) : 1,
  parameter int DIV_W = SPIM_DIV_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               cfg_write,
  input  logic [SELW-1:0]    cfg_set,
  input  logic [4:0]         cfg_size_m1,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_lsb_first,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               push_valid,
  input  logic [SPIM_DW-1:0] push_data,
  input  logic [SELW-1:0]    push_set,
  input  logic [NCS-1:0]     push_cs_mask,
  input  logic               push_keep_cs,
  output logic               tx_full,
  output logic               tx_empty,
  input  logic               rx_pop,
  output logic [SPIM_DW-1:0] rx_data,
  output logic               rx_full,
  output logic               rx_empty,
  output logic               rx_stall,
  output logic               sck,
  output logic [NCS-1:0]     cs_n,
  output logic               sout,
  input  logic               sin
);
  localparam int TXW = SPIM_DW + SELW + NCS + 1;

  logic [TXW-1:0]     tx_in, tx_head;
  logic [SPIM_DW-1:0] head_data, rx_word;
  logic [SELW-1:0]    head_set;
  logic [NCS-1:0]     head_mask;
  logic               head_cont, tx_pop, rx_push;
  spim_attr_t         wattr, head_attr;

  assign tx_in = {push_keep_cs, push_cs_mask, push_set, push_data};
  assign {head_cont, head_mask, head_set, head_data} = tx_head;
  assign wattr = '{size_m1: cfg_size_m1, cpol: cfg_cpol, cpha: cfg_cpha,
                   lsbf: cfg_lsb_first, div: SPIM_DIV_W'(cfg_div)};

  spim_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(push_valid), .wdata(tx_in), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  spim_attr_bank #(.NSET(NSET), .SELW(SELW)) u_bank (
    .clk(clk), .rst(rst), .we(cfg_write), .wsel(cfg_set), .wattr(wattr),
    .rsel(head_set), .rattr(head_attr));

  spim_engine #(.NCS(NCS)) u_eng (
    .clk(clk), .rst(rst), .en(en), .tx_empty(tx_empty), .head_data(head_data),
    .head_mask(head_mask), .head_cont(head_cont), .head_attr(head_attr),
    .rx_full(rx_full), .sin(sin), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_word(rx_word), .sck(sck), .sout(sout), .rx_stall(rx_stall), .cs_n(cs_n));

  spim_fifo #(.W(SPIM_DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_data), .full(rx_full), .empty(rx_empty));
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           sck,
  input logic [NCS-1:0] cs_n,
  input logic           rx_stall,
  input logic           rx_full,
  input logic           rx_empty,
  input logic           tx_full,
  input logic           tx_empty
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((&cs_n) && !rx_stall && rx_empty));

  a_r7_select_release: assert property (@(posedge clk) disable iff (rst)
    (!(&$past(cs_n)) && (cs_n != $past(cs_n))) |-> (&cs_n));

  a_r8_lead_quiet: assert property (@(posedge clk) disable iff (rst)
    ((&$past(cs_n)) && !(&cs_n)) |=> $stable(sck));

  a_r10_rx_flags: assert property (@(posedge clk) disable iff (rst)
    !(rx_full && rx_empty));

  a_r12_tx_flags: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty));

  a_r11_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    rx_stall |-> $stable(sck));
endmodule

bind spim_cmd_master spim_checker #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .rx_stall(rx_stall),
  .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty));

// File: tb/tb_spim_cmd_master.sv
module tb_spim_cmd_master;
  logic        clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic        cfg_write = 1'b0, cfg_set = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [4:0]  cfg_size_m1 = '0;
  logic [7:0]  cfg_div = '0;
  logic        push_valid = 1'b0, push_set = 1'b0, push_keep_cs = 1'b0;
  logic [31:0] push_data = '0;
  logic [3:0]  push_cs_mask = '0;
  logic        tx_full, tx_empty, rx_pop = 1'b0, rx_full, rx_empty, rx_stall, sck, sout;
  logic        sin = 1'b0;
  logic [31:0] rx_data;
  logic [3:0]  cs_n;

  always #2 clk = ~clk;

  spim_cmd_master dut (.*);

  typedef struct packed {
    logic [31:0] data;
    logic [4:0]  sz;
    logic        cpol, cpha, lsbf;
    logic [7:0]  div;
    logic [3:0]  mask;
  } frm_t;

  frm_t        fq[$];
  logic [31:0] rxq[$];
  logic [4:0]  c_sz[2];
  logic        c_cpol[2], c_cpha[2], c_lsbf[2];
  logic [7:0]  c_div[2];
  int nchk = 0, nfail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bpos(frm_t f, int j);
    return f.lsbf ? j : int'(f.sz) - j;
  endfunction
  function automatic logic [31:0] szmask(logic [4:0] s);
    return (s == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (s + 1)) - 32'd1);
  endfunction
  function automatic logic [31:0] rep(frm_t f);
    return f.data ^ 32'h5A3C_C3A5;
  endfunction

  // behavioural slave and per-clock bus model
  logic s_prev_sck, s_prev_csall, csall, lead;
  logic [31:0] s_cap;
  int s_edges, s_bits, s_since, s_last_div, s_rises, s_frames;
  bit s_per_ok, s_mask_ok;
  frm_t cf;

  always @(negedge clk) begin
    if (rst) begin
      s_prev_sck = 1'b0; s_prev_csall = 1'b1; s_cap = '0;
      s_edges = 0; s_bits = 0; s_since = 0; s_last_div = 0;
      s_per_ok = 1; s_mask_ok = 1; sin = 1'b0;
    end else begin
      csall = &cs_n;
      s_since++;
      if (s_prev_csall && !csall) begin
        if (fq.size() == 0) chk(0, "R2 select without queued frame", {28'd0, cs_n}, 32'hF);
        else begin
          s_edges = 0; s_bits = 0; s_cap = '0; s_per_ok = 1; s_mask_ok = 1; s_since = 0;
          if (!fq[0].cpha) sin = rep(fq[0])[bpos(fq[0], 0)];
        end
      end else if (sck != s_prev_sck) begin
        if (csall || fq.size() == 0) chk(0, "R7 clock edge while deselected", {31'd0, sck}, {31'd0, s_prev_sck});
        else begin
          cf = fq[0];
          lead = (sck != cf.cpol);
          if (s_edges == 0) chk(s_since >= int'(cf.div) + 1, "R8 lead delay", s_since, int'(cf.div) + 1);
          else if (s_since != int'(cf.div) + 1) s_per_ok = 0;
          if (cs_n != ~cf.mask) s_mask_ok = 0;
          if (lead ^ cf.cpha) begin
            s_cap[bpos(cf, s_bits)] = sout;
            s_bits++;
          end else if (s_bits <= int'(cf.sz)) begin
            sin = rep(cf)[bpos(cf, s_bits)];
          end
          s_edges++; s_since = 0;
          if (s_edges == 2 * (int'(cf.sz) + 1)) begin
            chk(s_cap == (cf.data & szmask(cf.sz)), "R3 R5 R6 bits on sout", s_cap, cf.data & szmask(cf.sz));
            chk(s_per_ok, "R8 half period", 0, 1);
            chk(s_mask_ok, "R7 select pattern", {28'd0, cs_n}, {28'd0, ~cf.mask});
            rxq.push_back(rep(cf) & szmask(cf.sz));
            s_last_div = int'(cf.div);
            s_frames++;
            void'(fq.pop_front());
            s_edges = 0; s_bits = 0; s_cap = '0; s_per_ok = 1; s_mask_ok = 1;
            if (fq.size() != 0 && !fq[0].cpha) sin = rep(fq[0])[bpos(fq[0], 0)];
          end
        end
      end
      if (!s_prev_csall && csall) begin
        s_rises++;
        chk(s_since >= s_last_div + 1, "R8 trail delay", s_since, s_last_div + 1);
      end
      s_prev_sck = sck; s_prev_csall = csall;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic cfg(input bit s, input [4:0] sz, input bit pol, input bit pha, input bit lsb, input [7:0] dv);
    @(negedge clk);
    cfg_write = 1; cfg_set = s; cfg_size_m1 = sz; cfg_cpol = pol; cfg_cpha = pha;
    cfg_lsb_first = lsb; cfg_div = dv;
    c_sz[s] = sz; c_cpol[s] = pol; c_cpha[s] = pha; c_lsbf[s] = lsb; c_div[s] = dv;
    @(negedge clk);
    cfg_write = 0;
  endtask

  task automatic push(input [31:0] d, input bit s, input [3:0] m, input bit k);
    frm_t f;
    @(negedge clk);
    if (!tx_full) begin
      f.data = d; f.sz = c_sz[s]; f.cpol = c_cpol[s]; f.cpha = c_cpha[s];
      f.lsbf = c_lsbf[s]; f.div = c_div[s]; f.mask = m;
      fq.push_back(f);
    end
    push_valid = 1; push_data = d; push_set = s; push_cs_mask = m; push_keep_cs = k;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (fq.size() == 0 && (&cs_n)) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && (rxq.size() > 0 || fq.size() > 0); i++) begin
      @(negedge clk);
      rx_pop = 0;
      if (!rx_empty) begin
        if (rxq.size() > 0) begin
          chk(rx_data == rxq[0], "R10 receive order and value", rx_data, rxq[0]);
          void'(rxq.pop_front());
        end else chk(0, "R10 unexpected receive word", rx_data, 0);
        rx_pop = 1;
      end
    end
    @(negedge clk);
    rx_pop = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int f0, r0;
    logic sk;
    for (int s = 0; s < 2; s++) begin
      c_sz[s] = 5'd7; c_cpol[s] = 0; c_cpha[s] = 0; c_lsbf[s] = 0; c_div[s] = 8'd1;
    end
    s_rises = 0; s_frames = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(cs_n == 4'hF, "R1 cs_n after reset", cs_n, 4'hF);
    chk(!sck && !sout, "R1 sck/sout after reset", {sck, sout}, 0);
    chk(tx_empty && rx_empty && !tx_full && !rx_full && !rx_stall, "R1 flags after reset",
        {tx_empty, rx_empty, tx_full, rx_full, rx_stall}, 5'b11000);

    // R2: enable gating, default attribute set
    push(32'h0000_00C3, 0, 4'b0001, 0);
    repeat (30) @(negedge clk);
    chk(cs_n == 4'hF && !tx_empty, "R2 held while disabled", {tx_empty, cs_n}, 5'h0F);
    en = 1;
    drain();

    // R3 R5 R6: frame-by-frame attribute changes
    cfg(0, 5'd7, 0, 0, 0, 8'd1);
    cfg(1, 5'd15, 1, 1, 1, 8'd0);
    push(32'hDEAD_BEEF, 0, 4'b0001, 0);
    push(32'h1234_5678, 1, 4'b0100, 0);
    push(32'h0000_0081, 0, 4'b0010, 0);
    push(32'hFFFF_A55A, 1, 4'b1000, 0);
    drain();
    chk(sck == 1'b1, "R4 idle level after CPOL 1 frame", sck, 1);

    cfg(0, 5'd31, 0, 1, 0, 8'd2);
    cfg(1, 5'd0, 1, 0, 1, 8'd3);
    push(32'hC001_D00D, 0, 4'b0011, 0);
    push(32'h0000_0001, 1, 4'b0001, 0);
    push(32'h8421_0F0F, 0, 4'b0100, 0);
    push(32'h0000_0000, 1, 4'b1000, 0);
    drain();
    chk(sck == 1'b1, "R4 idle level after 1-bit frame", sck, 1);

    // R9: keep-select, same mask then different masks
    cfg(0, 5'd11, 0, 0, 1, 8'd1);
    en = 0;
    push(32'h0000_0ABC, 0, 4'b0010, 1);
    push(32'h0000_0123, 0, 4'b0010, 0);
    r0 = s_rises;
    en = 1;
    drain();
    chk(s_rises - r0 == 1, "R9 select held between matching frames", s_rises - r0, 1);
    en = 0;
    push(32'h0000_0555, 0, 4'b0010, 1);
    push(32'h0000_0AAA, 0, 4'b1000, 0);
    r0 = s_rises;
    en = 1;
    drain();
    chk(s_rises - r0 == 2, "R9 select released on mask change", s_rises - r0, 2);

    // R12: overfull transmit queue
    en = 0;
    cfg(0, 5'd7, 0, 0, 0, 8'd0);
    for (int i = 0; i < 4; i++) push(32'h10 + i, 0, 4'b0001, 0);
    chk(tx_full, "R12 full after four pushes", tx_full, 1);
    push(32'h0000_00EE, 0, 4'b0001, 0);
    f0 = s_frames;
    en = 1;
    drain();
    chk(s_frames - f0 == 4, "R12 dropped push made no frame", s_frames - f0, 4);
    chk(tx_empty, "R12 queue empty after run", tx_empty, 1);

    // R11: receive queue full at frame end
    en = 0;
    for (int i = 0; i < 4; i++) push(32'h60 + i, 0, 4'b0100, 0);
    en = 1;
    for (int i = 0; i < 2000 && !tx_empty; i++) @(negedge clk);
    push(32'h0000_0077, 0, 4'b0100, 0);
    for (int i = 0; i < 2000 && !rx_stall; i++) @(negedge clk);
    chk(rx_stall && rx_full, "R11 stall raised with queue full", {rx_stall, rx_full}, 2'b11);
    chk(cs_n == 4'b1011, "R11 select held during stall", cs_n, 4'b1011);
    sk = sck;
    repeat (20) @(negedge clk);
    chk(rx_stall && sck == sk && cs_n == 4'b1011, "R11 bus frozen while stalled",
        {rx_stall, sck, cs_n}, {1'b1, sk, 4'b1011});
    drain();
    chk(!rx_stall && cs_n == 4'hF && rx_empty, "R11 stall cleared after pop",
        {rx_stall, rx_empty, cs_n}, {2'b01, 4'hF});

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule